// File: doc/BRIEF.md
# Quadrature Position Decoder

This block turns two phase pins from a rotary or linear encoder into a signed position. Each pin is first brought into the clock domain by a short synchronizer. It can then be inverted by its own polarity control, and it passes through its own glitch filter with a programmable length. A decoder watches the two filtered levels. In quadrature mode it produces one step for every legal edge of either phase. In count/direction mode, phase A acts as a count clock and phase B gives the direction.

Each step drives a one-cycle increment or decrement pulse and moves a 16-bit position counter. The counter wraps between zero and a programmable modulo value, and each wrap raises a one-cycle overflow flag. The block is meant to sit between the encoder pins and a timer core. Register access and index-pulse handling belong to the surrounding logic.

Top module: `quad_pos_decoder`

## Requirements
- R1: While the asynchronous active-low reset is held, and in the first cycle after it is released, `pos_o` is 0 and `inc_o`, `dec_o` and `wrap_o` are 0.
- R2: When `pol_a_i` (or `pol_b_i`) is 1, that phase is inverted before filtering and decoding. Flipping one polarity bit while the pins are quiet is therefore seen as one edge on that phase.
- R3: With `mode_i` = 0, each change of exactly one filtered phase makes exactly one step. The sequence {A,B} = 00, 10, 11, 01, 00 (A leading) counts up, and the reverse sequence counts down. `inc_o` or `dec_o` is high for that one cycle and never both at once.
- R4: With `mode_i` = 0, a cycle in which both filtered phases change together makes no step.
- R5: With `mode_i` = 1, only a rising edge of filtered A makes a step. The step is up when filtered B is 1 in that same cycle and down when it is 0. Falling edges of A and any change of B make no step.
- R6: A filter length N (4 bits) accepts a new phase level only after the synchronized level has differed from the accepted level on N consecutive clocks. N = 0 and N = 1 both mean no filtering. A pulse shorter than N clocks is discarded.
- R7: An up step with `pos_o` >= `modulo_i` loads 0 and raises `wrap_o` for that cycle. Any other up step adds 1.
- R8: A down step with `pos_o` = 0 loads `modulo_i` and raises `wrap_o` for that cycle. Any other down step subtracts 1. Without a step, `pos_o` holds and `wrap_o` is 0.
- R9: With filter length 0, a pin change driven before a clock edge appears on `inc_o`/`dec_o`/`pos_o` after the fourth rising edge: two synchronizer stages, one filter register and one counter register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 0: quadrature decoding, 1: count/direction decoding |
| pol_a_i | input | 1 | Invert phase A when 1 |
| pol_b_i | input | 1 | Invert phase B when 1 |
| filt_a_i | input | 4 | Filter length for phase A, 0 disables |
| filt_b_i | input | 4 | Filter length for phase B, 0 disables |
| modulo_i | input | 16 | Highest counter value before wrapping |
| phase_a_i | input | 1 | Phase A pin (count pin in mode 1) |
| phase_b_i | input | 1 | Phase B pin (direction pin in mode 1) |
| inc_o | output | 1 | One-cycle pulse on each up step |
| dec_o | output | 1 | One-cycle pulse on each down step |
| pos_o | output | 16 | Position counter |
| wrap_o | output | 1 | One-cycle flag when the counter wraps |

## Verification
Two situations depend on events that land in the same cycle. In count/direction mode, a count edge on A and a direction change on B can reach the decoder in the same cycle. The bench drives both pins on the same clock with equal filter lengths and expects the step to follow the new B level. In quadrature mode, a change on both phases at once must be dropped rather than read as a step. The bench flips both pins together and expects the position to stay where it was. The bench also drives steps across the modulo boundary in both directions, so that a step and a wrap fall in one cycle. It judges every cycle against its behavioural model.

// File: rtl/qd_pkg.sv
package qd_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'b00,
    STEP_UP   = 2'b01,
    STEP_DOWN = 2'b10
  } step_e;
endpackage

// File: rtl/qd_glitch_filter.sv
// Synchronizer, polarity inversion and run-length glitch filter for one phase.
module qd_glitch_filter #(
  parameter int FILT_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_i,
  input  logic              invert_i,
  input  logic [FILT_W-1:0] limit_i,
  output logic              level_o
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic [SYNC_STAGES:0]   sync_ext;
  logic [FILT_W-1:0]      run_q, run_d, run_inc;
  logic                   lvl_q, lvl_d;
  logic                   sample;

  assign sync_ext = {sync_q, pin_i};
  assign sync_d   = sync_ext[SYNC_STAGES-1:0];
  assign sample   = sync_q[SYNC_STAGES-1] ^ invert_i;
  assign run_inc  = run_q + 1'b1;

  always_comb begin
    run_d = run_q;
    lvl_d = lvl_q;
    if (sample == lvl_q) begin
      run_d = '0;
    end else if (run_inc >= limit_i) begin
      lvl_d = sample;
      run_d = '0;
    end else begin
      run_d = run_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      run_q  <= '0;
      lvl_q  <= 1'b0;
    end else begin
      sync_q <= sync_d;
      run_q  <= run_d;
      lvl_q  <= lvl_d;
    end
  end

  assign level_o = lvl_q;
endmodule

// File: rtl/qd_step_decode.sv
// Turns two filtered phase levels into up/down steps.
module qd_step_decode
  import qd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  mode_i,
  input  logic  a_i,
  input  logic  b_i,
  output step_e step_o
);
  logic  a_prev_q, b_prev_q;
  logic  a_chg, b_chg, a_rise;
  step_e step_d;

  assign a_chg  = a_i ^ a_prev_q;
  assign b_chg  = b_i ^ b_prev_q;
  assign a_rise = a_i & ~a_prev_q;

  always_comb begin
    step_d = STEP_NONE;
    if (!mode_i) begin
      if (a_chg ^ b_chg) begin
        if ((a_chg && (a_i != b_i)) || (b_chg && (a_i == b_i)))
          step_d = STEP_UP;
        else
          step_d = STEP_DOWN;
      end
    end else if (a_rise) begin
      step_d = b_i ? STEP_UP : STEP_DOWN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_prev_q <= 1'b0;
      b_prev_q <= 1'b0;
    end else begin
      a_prev_q <= a_i;
      b_prev_q <= b_i;
    end
  end

  assign step_o = step_d;
endmodule

// File: rtl/qd_pos_counter.sv
// Modulo up/down position counter with registered step pulses.
module qd_pos_counter
  import qd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  step_e            step_i,
  input  logic [CNT_W-1:0] modulo_i,
  output logic [CNT_W-1:0] pos_o,
  output logic             inc_o,
  output logic             dec_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] pos_q, pos_d;
  logic             inc_q, dec_q, wrap_q;
  logic             inc_d, dec_d, wrap_d;

  always_comb begin
    pos_d  = pos_q;
    inc_d  = (step_i == STEP_UP);
    dec_d  = (step_i == STEP_DOWN);
    wrap_d = 1'b0;
    if (inc_d) begin
      if (pos_q >= modulo_i) begin
        pos_d  = '0;
        wrap_d = 1'b1;
      end else begin
        pos_d  = pos_q + 1'b1;
      end
    end else if (dec_d) begin
      if (pos_q == '0) begin
        pos_d  = modulo_i;
        wrap_d = 1'b1;
      end else begin
        pos_d  = pos_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      inc_q  <= 1'b0;
      dec_q  <= 1'b0;
      wrap_q <= 1'b0;
    end else begin
      pos_q  <= pos_d;
      inc_q  <= inc_d;
      dec_q  <= dec_d;
      wrap_q <= wrap_d;
    end
  end

  assign pos_o  = pos_q;
  assign inc_o  = inc_q;
  assign dec_o  = dec_q;
  assign wrap_o = wrap_q;
endmodule

// File: rtl/quad_pos_decoder.sv
module quad_pos_decoder #(
  parameter int CNT_W       = 16,
  parameter int FILT_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_i,
  input  logic              pol_a_i,
  input  logic              pol_b_i,
  input  logic [FILT_W-1:0] filt_a_i,
  input  logic [FILT_W-1:0] filt_b_i,
  input  logic [CNT_W-1:0]  modulo_i,
  input  logic              phase_a_i,
  input  logic              phase_b_i,
  output logic              inc_o,
  output logic              dec_o,
  output logic [CNT_W-1:0]  pos_o,
  output logic              wrap_o
);
  localparam int NPH = 2;

  logic [NPH-1:0]        pin_v, inv_v, lvl_v;
  logic [FILT_W-1:0]     lim_v [NPH];
  qd_pkg::step_e         step;

  assign pin_v    = {phase_b_i, phase_a_i};
  assign inv_v    = {pol_b_i, pol_a_i};
  assign lim_v[0] = filt_a_i;
  assign lim_v[1] = filt_b_i;

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    qd_glitch_filter #(
      .FILT_W      (FILT_W),
      .SYNC_STAGES (SYNC_STAGES)
    ) u_filt (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_i    (pin_v[p]),
      .invert_i (inv_v[p]),
      .limit_i  (lim_v[p]),
      .level_o  (lvl_v[p])
    );
  end

  qd_step_decode u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_i (mode_i),
    .a_i    (lvl_v[0]),
    .b_i    (lvl_v[1]),
    .step_o (step)
  );

  qd_pos_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_i   (step),
    .modulo_i (modulo_i),
    .pos_o    (pos_o),
    .inc_o    (inc_o),
    .dec_o    (dec_o),
    .wrap_o   (wrap_o)
  );
endmodule

// File: rtl/quad_pos_decoder_chk.sv
module quad_pos_decoder_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] modulo_i,
  input logic [CNT_W-1:0] pos_o,
  input logic             inc_o,
  input logic             dec_o,
  input logic             wrap_o
);
  // R3: a step is either up or down, never both
  a_r3_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc_o && dec_o));

  // R3 / R7: an up step below the limit adds one
  a_r7_up_plain: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_o && ($past(pos_o) < $past(modulo_i))) |-> (pos_o == $past(pos_o) + 1'b1) && !wrap_o);

  // R7: an up step at or above the limit wraps to zero
  a_r7_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_o && ($past(pos_o) >= $past(modulo_i))) |-> (pos_o == '0) && wrap_o);

  // R8: a down step from zero loads the limit
  a_r8_down_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_o && ($past(pos_o) == '0)) |-> (pos_o == $past(modulo_i)) && wrap_o);

  // R8: without a step the position holds and no wrap is flagged
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_o && !dec_o) |-> (pos_o == $past(pos_o)) && !wrap_o);
endmodule

bind quad_pos_decoder quad_pos_decoder_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .modulo_i (modulo_i),
  .pos_o    (pos_o),
  .inc_o    (inc_o),
  .dec_o    (dec_o),
  .wrap_o   (wrap_o)
);

// File: tb/sim_quad_pos_decoder.sv
module sim_quad_pos_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_i, pol_a_i, pol_b_i;
  logic [3:0]  filt_a_i, filt_b_i;
  logic [15:0] modulo_i;
  logic        phase_a_i, phase_b_i;
  logic        inc_o, dec_o, wrap_o;
  logic [15:0] pos_o;

  int checks = 0;
  int errors = 0;
  int wraps_seen = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_pos_decoder u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .pol_a_i(pol_a_i), .pol_b_i(pol_b_i),
    .filt_a_i(filt_a_i), .filt_b_i(filt_b_i), .modulo_i(modulo_i),
    .phase_a_i(phase_a_i), .phase_b_i(phase_b_i),
    .inc_o(inc_o), .dec_o(dec_o), .pos_o(pos_o), .wrap_o(wrap_o)
  );

  // Behavioural reference model
  int qa[$];
  int qb[$];
  int m_fa, m_fb, m_pa, m_pb, m_ra, m_rb;
  int m_pos, m_inc, m_dec, m_wrap;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qa = '{0, 0};
      qb = '{0, 0};
      m_fa = 0; m_fb = 0; m_pa = 0; m_pb = 0; m_ra = 0; m_rb = 0;
      m_pos = 0; m_inc = 0; m_dec = 0; m_wrap = 0;
    end else begin
      int dir;
      int sa, sb;
      dir = 0;
      if (!mode_i) begin
        if ((m_fa != m_pa) != (m_fb != m_pb)) begin
          if (((m_fa != m_pa) && (m_fa != m_fb)) || ((m_fb != m_pb) && (m_fa == m_fb))) dir = 1;
          else dir = -1;
        end
      end else if (m_fa == 1 && m_pa == 0) begin
        dir = (m_fb == 1) ? 1 : -1;
      end
      m_inc = (dir == 1); m_dec = (dir == -1); m_wrap = 0;
      if (dir == 1) begin
        if (m_pos >= int'(modulo_i)) begin m_pos = 0; m_wrap = 1; end
        else m_pos = m_pos + 1;
      end else if (dir == -1) begin
        if (m_pos == 0) begin m_pos = int'(modulo_i); m_wrap = 1; end
        else m_pos = m_pos - 1;
      end
      m_pa = m_fa; m_pb = m_fb;
      sa = qa.pop_front() ^ int'(pol_a_i);
      sb = qb.pop_front() ^ int'(pol_b_i);
      if (sa == m_fa) m_ra = 0;
      else if (m_ra + 1 >= int'(filt_a_i)) begin m_fa = sa; m_ra = 0; end
      else m_ra = m_ra + 1;
      if (sb == m_fb) m_rb = 0;
      else if (m_rb + 1 >= int'(filt_b_i)) begin m_fb = sb; m_rb = 0; end
      else m_rb = m_rb + 1;
      qa.push_back(int'(phase_a_i));
      qb.push_back(int'(phase_b_i));
    end
  end

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R7 pos vs model", int'(pos_o), m_pos);
      chk("R3 inc vs model", int'(inc_o), m_inc);
      chk("R3 dec vs model", int'(dec_o), m_dec);
      chk("R8 wrap vs model", int'(wrap_o), m_wrap);
      if (wrap_o) wraps_seen++;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // Quadrature step from the current pin pair; up follows 00,10,11,01
  task automatic qstep(bit up, int hold);
    logic [1:0] s;
    s = {phase_a_i, phase_b_i};
    if (up) begin
      case (s)
        2'b00: phase_a_i = 1'b1;
        2'b10: phase_b_i = 1'b1;
        2'b11: phase_a_i = 1'b0;
        default: phase_b_i = 1'b0;
      endcase
    end else begin
      case (s)
        2'b00: phase_b_i = 1'b1;
        2'b01: phase_a_i = 1'b1;
        2'b11: phase_b_i = 1'b0;
        default: phase_a_i = 1'b0;
      endcase
    end
    cyc(hold);
  endtask

  function automatic void finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endfunction

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int p;
    rst_n = 1'b0; mode_i = 1'b0; pol_a_i = 1'b0; pol_b_i = 1'b0;
    filt_a_i = 4'd0; filt_b_i = 4'd0; modulo_i = 16'hFFFF;
    phase_a_i = 1'b0; phase_b_i = 1'b0;
    cyc(3);
    chk("R1 reset pos", int'(pos_o), 0);
    chk("R1 reset inc", int'(inc_o), 0);
    chk("R1 reset dec", int'(dec_o), 0);
    chk("R1 reset wrap", int'(wrap_o), 0);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 first cycle pos", int'(pos_o), 0);
    cyc(4);

    // R9 latency: drive at a falling edge, pulse after the fourth rising edge
    phase_a_i = 1'b1;
    cyc(3);
    chk("R9 no pulse after three edges", int'(inc_o), 0);
    cyc(1);
    chk("R9 pulse after four edges", int'(inc_o), 1);
    chk("R9 pos after four edges", int'(pos_o), 1);
    cyc(4);

    // R3 forward and backward
    repeat (7) qstep(1'b1, 6);
    cyc(4);
    chk("R3 eight up steps", int'(pos_o), 8);
    repeat (3) qstep(1'b0, 6);
    cyc(4);
    chk("R3 three down steps", int'(pos_o), 5);

    // R4 both phases together
    phase_a_i = ~phase_a_i; phase_b_i = ~phase_b_i;
    cyc(8);
    chk("R4 double change ignored", int'(pos_o), 5);

    // R7 / R8 wrap with a small modulo
    modulo_i = 16'd6;
    wraps_seen = 0;
    qstep(1'b1, 6);
    qstep(1'b1, 6);
    cyc(2);
    chk("R7 up wrap to zero", int'(pos_o), 0);
    chk("R7 wrap flagged once", wraps_seen, 1);
    qstep(1'b0, 8);
    chk("R8 down wrap to modulo", int'(pos_o), 6);
    chk("R8 wrap flagged again", wraps_seen, 2);

    // R2 polarity flip seen as an edge
    pol_a_i = 1'b1;
    cyc(8);
    chk("R2 polarity flip moves", int'(pos_o != 16'd6), 1);
    pol_a_i = 1'b0;
    cyc(8);
    chk("R2 polarity restore returns", int'(pos_o), 6);

    // R6 glitch filter on phase A
    filt_a_i = 4'd5;
    cyc(2);
    p = int'(pos_o);
    phase_a_i = ~phase_a_i;
    cyc(3);
    phase_a_i = ~phase_a_i;
    cyc(14);
    chk("R6 short pulse rejected", int'(pos_o), p);
    phase_a_i = ~phase_a_i;
    cyc(14);
    chk("R6 long level accepted", int'(pos_o != 16'(p)), 1);
    filt_a_i = 4'd0;

    // R5 count/direction mode
    phase_a_i = 1'b0; phase_b_i = 1'b1;
    cyc(8);
    mode_i = 1'b1;
    cyc(4);
    p = int'(pos_o);
    phase_a_i = 1'b1;
    cyc(8);
    chk("R5 rising edge with B high counts up", int'(pos_o), (p + 1) % 7);
    phase_a_i = 1'b0;
    cyc(8);
    chk("R5 falling edge ignored", int'(pos_o), (p + 1) % 7);
    phase_b_i = 1'b0;
    cyc(8);
    chk("R5 direction change alone ignored", int'(pos_o), (p + 1) % 7);
    phase_a_i = 1'b1;
    cyc(8);
    chk("R5 rising edge with B low counts down", int'(pos_o), p);
    phase_a_i = 1'b0;
    cyc(8);
    // R5 count edge and direction change in the same cycle
    phase_a_i = 1'b1; phase_b_i = 1'b1;
    cyc(8);
    chk("R5 coincident edge uses new direction", int'(pos_o), (p + 1) % 7);

    cyc(4);
    finish_run();
  end
endmodule